// File: doc/BRIEF.md
# B-Channel Time-Slot Serial Port

This block is the digital edge of a single voice channel on a 2B+D style ISDN link. The shared frame carries two 8-bit bearer slots, called B1 and B2, with a two-bit gap between them. The port places one outgoing 8-bit sample into the slot that the slot-select line picks. It also collects the 8-bit sample that arrives in that same slot. Companding, the D channel and all analog work happen elsewhere.

The bit clock, sync pulse, receive line, slot select and mode strap arrive asynchronously. Each is resynchronised into the system clock domain, and the bit-clock edges are found there. Transmit bits change after rising bit-clock edges. Receive bits are taken on falling edges. The transmit line has its own enable, so the pad can float whenever the port does not own the line. The port works only after the strap pin has shown the link mode for long enough. While it waits, the line stays released and nothing is received.

Top module: `bchan_serial_port`

## Requirements
- R1: After reset, `tx_en`, `tx_data`, `rx_valid` and `link_mode` are all 0.
- R2: `link_mode` goes to 1 only when `strap_pin` has stayed high through three successive rising edges of `frame_sync`, which spans two complete frame periods. It returns to 0 within a few system clocks after `strap_pin` goes low.
- R3: While `link_mode` is 0, `tx_en` stays 0 and `rx_valid` never pulses.
- R4: With `slot_sel` = 0 (B1), the bits of the latched byte are driven MSB first, one in each bit period that follows rising bit-clock edges 1 to 8. Edge 0 is the rising edge at which `frame_sync` is seen high.
- R5: With `slot_sel` = 1 (B2), the same bits are driven MSB first after rising edges 11 to 18.
- R6: Outside the selected slot, `tx_en` is 0. This covers edges 9 and 10, the other B slot and the rest of the frame. `tx_data` is 0 whenever `tx_en` is 0.
- R7: Receive bits are taken from `rx_data` on the falling bit-clock edges 1 to 8 (B1) or 11 to 18 (B2), MSB first, and are presented on `rx_byte`.
- R8: `rx_valid` is a single system-clock pulse issued once per frame, just after the eighth bit of the selected slot has been taken.
- R9: `tx_byte` and `slot_sel` are captured at frame start. A change to `tx_byte` during a frame does not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame sync pulse, one bit period wide |
| bit_clk | input | 1 | Link bit clock |
| rx_data | input | 1 | Serial receive line |
| slot_sel | input | 1 | Slot choice: 0 selects B1, 1 selects B2 |
| strap_pin | input | 1 | Mode strap; held high selects this link mode |
| tx_byte | input | SLOT_BITS | Outgoing sample for the next frame |
| tx_data | output | 1 | Serial transmit bit |
| tx_en | output | 1 | Output enable for the transmit pad |
| rx_byte | output | SLOT_BITS | Last received sample |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_byte` |
| link_mode | output | 1 | Link mode detected and active |

## Verification
The bench uses the default parameters: 8-bit slots, B2 starting at edge 11, two synchronizer stages and a two-period strap qualification. It runs a 24-bit frame, with the bit clock at one sixteenth of the system clock. At that ratio, every slot edge, both guard bits and the idle tail of the frame can be sampled directly, bit period by bit period. The first two frames fall inside the strap qualification window, so the disabled behaviour can be observed before the port arms. A mid-frame byte change and a strap drop then cover the latch and disarm paths.

// File: rtl/bchan_pkg.sv
// Shared types for the B-channel serial port.
package bchan_pkg;

    // Which bearer slot of the frame is used.
    typedef enum logic {
        SLOT_B1 = 1'b0,
        SLOT_B2 = 1'b1
    } slot_e;

    // Strobes from the slot timer to the data path, each one system clock wide.
    typedef struct packed {
        logic load;   // frame start: capture the outgoing byte
        logic drive;  // rising edge inside the selected slot
        logic idle;   // rising edge outside the selected slot
        logic take;   // falling edge inside the selected slot
        logic done;   // falling edge on the last bit of the slot
    } strobe_t;

endpackage

// File: rtl/bchan_sync_bus.sv
// Multi-stage resynchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherency is implied.
module bchan_sync_bus #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/bchan_mode_detect.sv
// Qualifies the link mode from the strap pin: the strap must stay high
// across PERIODS complete sync periods. Assumes synchronised inputs.
module bchan_mode_detect #(
    parameter int PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_s,
    input  logic strap_s,
    output logic mode_on
);

    localparam int MC_W = $clog2(PERIODS + 2);
    localparam logic [MC_W-1:0] ARMED = MC_W'(PERIODS + 1);

    logic [MC_W-1:0] edges_q;
    logic            sync_q;

    // Count sync rises under a continuously high strap; clear on a low strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
            mode_on <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            sync_q <= sync_s;
            if (!strap_s) begin
                edges_q <= '0;
                mode_on <= 1'b0;
            end else if (sync_s && !sync_q) begin
                if (edges_q != ARMED) edges_q <= edges_q + MC_W'(1);
                if (edges_q == ARMED - MC_W'(1)) mode_on <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bchan_slot_timer.sv
// Finds bit-clock edges, counts rising edges since the sync pulse and
// decodes the selected slot into strobes. Edge 0 is the rising edge that
// sees sync high; falling edge n follows rising edge n.
module bchan_slot_timer
    import bchan_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int B2_FIRST  = 11,
    parameter int IDX_W     = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             sync_s,
    input  logic             sel_s,
    output strobe_t          stb,
    output logic [IDX_W-1:0] tx_idx
);

    localparam int CNT_W = $clog2(B2_FIRST + SLOT_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_IDLE = '1;
    localparam logic [CNT_W-1:0] B1_LO    = CNT_W'(1);
    localparam logic [CNT_W-1:0] B2_LO    = CNT_W'(B2_FIRST);
    localparam logic [CNT_W-1:0] SPAN     = CNT_W'(SLOT_BITS);

    logic             bclk_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    slot_e            slot_q;
    logic             rise, fall;
    logic [CNT_W-1:0] slot_lo;

    function automatic logic in_slot(input logic [CNT_W-1:0] n, input logic [CNT_W-1:0] lo);
        return (n >= lo) && (n < lo + SPAN);
    endfunction

    assign rise    = bclk_s && !bclk_q;
    assign fall    = !bclk_s && bclk_q;
    assign slot_lo = (slot_q == SLOT_B2) ? B2_LO : B1_LO;

    // Next edge count: restart on a sync edge, saturate when idle.
    always_comb begin
        cnt_nxt = cnt_q;
        if (rise) begin
            if (sync_s)                 cnt_nxt = '0;
            else if (cnt_q != CNT_IDLE) cnt_nxt = cnt_q + CNT_W'(1);
        end
    end

    // Edge history, edge count and per-frame slot choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            cnt_q  <= CNT_IDLE;
            slot_q <= SLOT_B1;
        end else begin
            bclk_q <= bclk_s;
            cnt_q  <= cnt_nxt;
            if (rise && sync_s) slot_q <= slot_e'(sel_s);
        end
    end

    // Slot decode into one-clock strobes.
    always_comb begin
        stb.load  = rise && sync_s;
        stb.drive = rise && in_slot(cnt_nxt, slot_lo);
        stb.idle  = rise && !in_slot(cnt_nxt, slot_lo);
        stb.take  = fall && in_slot(cnt_q, slot_lo);
        stb.done  = fall && in_slot(cnt_q, slot_lo) && (cnt_q == slot_lo + SPAN - CNT_W'(1));
        tx_idx    = IDX_W'(cnt_nxt - slot_lo);
    end

endmodule

// File: rtl/bchan_data_path.sv
// Transmit serialiser with pad enable and receive deserialiser, both
// stepped by the slot timer strobes and gated by the link mode.
module bchan_data_path
    import bchan_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_on,
    input  strobe_t              stb,
    input  logic [IDX_W-1:0]     tx_idx,
    input  logic [SLOT_BITS-1:0] tx_byte,
    input  logic                 rxd_s,
    output logic                 tx_data,
    output logic                 tx_en,
    output logic [SLOT_BITS-1:0] rx_byte,
    output logic                 rx_valid
);

    logic [SLOT_BITS-1:0] hold_q;
    logic [SLOT_BITS-1:0] shift_q;

    // Capture the outgoing byte once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (stb.load) hold_q <= tx_byte;
    end

    // Drive one bit per slot period MSB first; release the line otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_on) begin
            tx_data <= 1'b0;
            tx_en   <= 1'b0;
        end else if (stb.drive) begin
            tx_data <= hold_q[SLOT_BITS-1-int'(tx_idx)];
            tx_en   <= 1'b1;
        end else if (stb.idle) begin
            tx_data <= 1'b0;
            tx_en   <= 1'b0;
        end
    end

    // Shift in received bits and publish the byte after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q  <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (stb.take) shift_q <= {shift_q[SLOT_BITS-2:0], rxd_s};
            if (stb.done && mode_on) begin
                rx_byte  <= {shift_q[SLOT_BITS-2:0], rxd_s};
                rx_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bchan_serial_port.sv
// Top of the B-channel serial port: resynchronises the link pins, qualifies
// the mode strap, times the slots and moves one byte each way per frame.
// Assumes clk runs at several times the bit-clock rate.
module bchan_serial_port
    import bchan_pkg::*;
#(
    parameter int SLOT_BITS    = 8,
    parameter int B2_FIRST     = 11,
    parameter int SYNC_STAGES  = 2,
    parameter int MODE_PERIODS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sync,
    input  logic                 bit_clk,
    input  logic                 rx_data,
    input  logic                 slot_sel,
    input  logic                 strap_pin,
    input  logic [SLOT_BITS-1:0] tx_byte,
    output logic                 tx_data,
    output logic                 tx_en,
    output logic [SLOT_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 link_mode
);

    localparam int IDX_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic             sync_s, bclk_s, rxd_s, sel_s, strap_s;
    strobe_t          stb;
    logic [IDX_W-1:0] tx_idx;

    bchan_sync_bus #(.WIDTH(5), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({strap_pin, slot_sel, rx_data, frame_sync, bit_clk}),
        .dout ({strap_s, sel_s, rxd_s, sync_s, bclk_s})
    );

    bchan_mode_detect #(.PERIODS(MODE_PERIODS)) i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_s (sync_s),
        .strap_s(strap_s),
        .mode_on(link_mode)
    );

    bchan_slot_timer #(.SLOT_BITS(SLOT_BITS), .B2_FIRST(B2_FIRST), .IDX_W(IDX_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk_s(bclk_s),
        .sync_s(sync_s),
        .sel_s (sel_s),
        .stb   (stb),
        .tx_idx(tx_idx)
    );

    bchan_data_path #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) i_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (link_mode),
        .stb     (stb),
        .tx_idx  (tx_idx),
        .tx_byte (tx_byte),
        .rxd_s   (rxd_s),
        .tx_data (tx_data),
        .tx_en   (tx_en),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid)
    );

endmodule

// File: rtl/bchan_serial_port_chk.sv
// Property checker for the B-channel serial port, bound into every instance.
module bchan_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_data,
    input logic tx_en,
    input logic rx_valid,
    input logic link_mode,
    input logic strap_s
);

    // R2: the mode flag can only rise while the resynchronised strap is high.
    a_r2_rise_needs_strap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_mode) |-> $past(strap_s));

    // R2: a low strap clears the mode flag on the next clock.
    a_r2_strap_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_s |=> !link_mode);

    // R3: the pad is enabled only from a cycle in which the mode was active.
    a_r3_enable_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> $past(link_mode));

    // R3: a received byte is only published while the mode was active.
    a_r3_valid_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(link_mode));

    // R6: the data line is quiet while the pad is released.
    a_r6_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_data);

    // R8: the receive strobe lasts a single clock.
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind bchan_serial_port bchan_serial_port_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_data  (tx_data),
    .tx_en    (tx_en),
    .rx_valid (rx_valid),
    .link_mode(link_mode),
    .strap_s  (strap_s)
);

// File: tb/test_bchan_serial_port.sv
// Directed bench: each frame task drives one frame and checks its own results.
module test_bchan_serial_port;

    localparam int FRAME_BITS = 24;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       bit_clk = 1'b0;
    logic       rx_data = 1'b1;
    logic       slot_sel = 1'b0;
    logic       strap_pin = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_data, tx_en, rx_valid, link_mode;
    logic [7:0] rx_byte;

    int         checks = 0;
    int         errors = 0;
    int         valid_seen = 0;
    logic [7:0] last_rx = 8'h00;

    always #4 clk = ~clk;

    bchan_serial_port i_bchan_serial_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_sync(frame_sync),
        .bit_clk   (bit_clk),
        .rx_data   (rx_data),
        .slot_sel  (slot_sel),
        .strap_pin (strap_pin),
        .tx_byte   (tx_byte),
        .tx_data   (tx_data),
        .tx_en     (tx_en),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .link_mode (link_mode)
    );

    // Record every receive strobe away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            valid_seen = valid_seen + 1;
            last_rx    = rx_byte;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic half_period();
        repeat (HALF) @(negedge clk);
    endtask

    // One frame; sync must already be high. Leaves sync high for the next frame.
    task automatic do_frame(input bit mode_exp, input bit ch, input logic [7:0] tx_now,
                            input logic [7:0] tx_late, input bit swap_mid,
                            input logic [7:0] rx_pat);
        int lo;
        int v0;
        lo       = ch ? 11 : 1;
        v0       = valid_seen;
        tx_byte  = tx_now;
        slot_sel = ch;
        for (int n = 0; n < FRAME_BITS; n++) begin
            bit in_slot;
            in_slot = (n >= lo) && (n < lo + 8);
            bit_clk = 1'b1;
            rx_data = in_slot ? rx_pat[7-(n-lo)] : 1'b1;
            if (swap_mid && n == 4) tx_byte = tx_late;
            half_period();
            if (n == 0) check("R2 mode flag at frame start", int'(link_mode), int'(mode_exp));
            if (mode_exp && in_slot) begin
                check(ch ? "R5 B2 enable" : "R4 B1 enable", int'(tx_en), 1);
                check(swap_mid ? "R9 byte latched at frame start" :
                      (ch ? "R5 B2 data" : "R4 B1 data"), int'(tx_data), int'(tx_now[7-(n-lo)]));
            end else begin
                check(mode_exp ? "R6 enable outside slot" : "R3 enable without mode", int'(tx_en), 0);
                check("R6 line low while released", int'(tx_data), 0);
            end
            bit_clk    = 1'b0;
            frame_sync = (n == FRAME_BITS - 1);
            half_period();
        end
        if (mode_exp) begin
            check("R8 one strobe per frame", valid_seen - v0, 1);
            check("R7 received byte", int'(last_rx), int'(rx_pat));
        end else begin
            check("R3 no strobe without mode", valid_seen - v0, 0);
        end
    endtask

    task automatic test_reset();
        strap_pin = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tx_en after reset", int'(tx_en), 0);
        check("R1 tx_data after reset", int'(tx_data), 0);
        check("R1 rx_valid after reset", int'(rx_valid), 0);
        check("R1 link_mode after reset", int'(link_mode), 0);
    endtask

    task automatic test_strap_drop();
        strap_pin = 1'b0;
        half_period();
        check("R2 mode cleared by low strap", int'(link_mode), 0);
    endtask

    initial begin
        test_reset();
        frame_sync = 1'b1;
        half_period();
        do_frame(1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 8'h3C); // qualifying, R3
        do_frame(1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0, 8'hC3); // qualifying, R3
        do_frame(1'b1, 1'b0, 8'hA5, 8'hA5, 1'b0, 8'h3C); // R4, R7
        do_frame(1'b1, 1'b1, 8'h5A, 8'hFF, 1'b1, 8'hC3); // R5, R9
        do_frame(1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 8'h81); // R5 next byte
        do_frame(1'b1, 1'b0, 8'h81, 8'h81, 1'b0, 8'h7E); // R4, R6
        test_strap_drop();
        do_frame(1'b0, 1'b0, 8'h96, 8'h96, 1'b0, 8'h69); // R3 after drop
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R1..R9 run): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule